// File: doc/BRIEF.md
# Single-Correction Modular Add/Subtract Unit

This unit adds or subtracts two 256-bit operands and brings the answer back into the range of a modulus held in its own 256-bit register. It performs no full reduction. It forms a 257-bit intermediate and then applies at most one correction. For an add, the modulus is taken off once when the sum reaches or passes it. For a subtract, the modulus is added once when the difference is negative. The corrected value is cut down to 256 bits and returned one cycle after the operation is accepted. The unit keeps no condition flags and never looks at any.

Operations arrive on a valid/ready stream. Each beat carries a 3-bit function code, a direction bit and the two operands. Results leave on a second valid/ready stream through a single output register. The input may be taken only while that register is empty, or while it is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While the consumer holds `out_ready` low, the result and `out_valid` stay frozen and no new beat is taken. The modulus is loaded and read back through a plain special-register port. Only index 0 selects the modulus register.

Top module: `pmod_addsub`

## Requirements
- R1: An accepted beat with function code 3'b101 and `in_sub`=0 yields `a+b` computed to 257 bits. If that sum is greater than or equal to the modulus, the modulus is subtracted once.
- R2: An accepted beat with function code 3'b101 and `in_sub`=1 yields `a-b` computed as a signed 257-bit value. If bit 256 of that value is set (the value is negative), the modulus is added once.
- R3: When both operands are below the modulus, the result equals the true `(a+b) mod M` or `(a-b) mod M`, and it is strictly below M.
- R4: The corrected intermediate is truncated to its low 256 bits, including for operands outside the range of R3.
- R5: `out_valid` rises in the cycle after an accepted beat with function code 3'b101, and it carries that beat's result.
- R6: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold their values and `in_ready` is low.
- R7: A beat accepted with any function code other than 3'b101 is consumed and produces no result.
- R8: A write with `sr_idx`=0 loads the modulus register, and `sr_rdata` shows it at index 0. A write at any other index changes nothing, and any other index reads as zero.
- R9: An operation uses the modulus held at the clock edge that accepts it. A modulus write in that same cycle affects only later operations.
- R10: After reset `out_valid` is 0 and the modulus register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_funct | input | 3 | Function code, 3'b101 selects this unit |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| in_a | input | 256 | First operand (minuend for subtract) |
| in_b | input | 256 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 256 | Corrected, truncated result |
| sr_idx | input | 4 | Special-register index |
| sr_wr | input | 1 | Special-register write strobe |
| sr_wdata | input | 256 | Special-register write data |
| sr_rdata | output | 256 | Special-register read data |

## Verification
The main function is exercised in several ways. Seeded random operands below a random modulus are compared both against the single-correction formula and against a true modular result, which shows whether the correction fires on the right side of the boundary. Directed cases cover the following. A sum that lands exactly on the modulus separates a greater-or-equal comparison from a strict one. A difference that goes just negative checks the add-back. Operands of all ones with a tiny modulus expose any error in the truncation or in the width of the intermediate. Further beats check stalling, foreign function codes, and a modulus write that coincides with an accepted operation.

// File: rtl/pmod_pkg.sv
package pmod_pkg;
  typedef enum logic {
    PM_ADD = 1'b0,
    PM_SUB = 1'b1
  } pm_dir_e;

  localparam logic [2:0] PM_FUNCT = 3'b101;
endpackage

// File: rtl/pmod_arith.sv
module pmod_arith #(
  parameter int W = 256
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] modulus,
  input  logic         is_sub,
  output logic [W-1:0] res
);
  localparam int IW = W + 1;

  logic [IW-1:0] sum_w, diff_w, mod_w;
  logic [IW-1:0] add_fix, sub_fix;
  logic          add_over, sub_neg;

  assign mod_w  = {1'b0, modulus};
  assign sum_w  = {1'b0, op_a} + {1'b0, op_b};
  assign diff_w = {1'b0, op_a} - {1'b0, op_b};

  // R1: reduce when the sum reaches the modulus
  assign add_over = (sum_w >= mod_w);
  assign add_fix  = add_over ? (sum_w - mod_w) : sum_w;

  // R2: top bit of the signed intermediate marks a negative difference
  assign sub_neg  = diff_w[IW-1];
  assign sub_fix  = sub_neg ? (diff_w + mod_w) : diff_w;

  // R4: truncate
  assign res = is_sub ? sub_fix[W-1:0] : add_fix[W-1:0];
endmodule

// File: rtl/pmod_modreg.sv
module pmod_modreg #(
  parameter int W       = 256,
  parameter int IDX_W   = 4,
  parameter int MOD_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sr_idx,
  input  logic             sr_wr,
  input  logic [W-1:0]     sr_wdata,
  output logic [W-1:0]     sr_rdata,
  output logic [W-1:0]     mod_q
);
  localparam logic [IDX_W-1:0] SEL = IDX_W'(MOD_IDX);

  logic hit;
  assign hit = (sr_idx == SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mod_q <= '0;
    else if (sr_wr && hit) mod_q <= sr_wdata;
  end

  assign sr_rdata = hit ? mod_q : '0;

  assert_mod_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr && hit) |=> (mod_q == $past(sr_wdata)));
  assert_mod_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sr_wr && hit)) |=> $stable(mod_q));
endmodule

// File: rtl/pmod_outreg.sv
module pmod_outreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drop,
  input  logic [W-1:0] data_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         take_ok
);
  assign take_ok = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take_ok) begin
      out_valid <= load;
      if (load) out_data <= data_in;
    end
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_stall_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !take_ok);
  assert_drop_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && take_ok) |=> !out_valid);
endmodule

// File: rtl/pmod_addsub.sv
module pmod_addsub #(
  parameter int W       = 256,
  parameter int IDX_W   = 4,
  parameter int MOD_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_funct,
  input  logic             in_sub,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  input  logic [IDX_W-1:0] sr_idx,
  input  logic             sr_wr,
  input  logic [W-1:0]     sr_wdata,
  output logic [W-1:0]     sr_rdata
);
  import pmod_pkg::*;

  logic [W-1:0] mod_q, calc;
  logic         ours, load, drop;
  pm_dir_e      dir;

  assign ours = (in_funct == PM_FUNCT);
  assign dir  = pm_dir_e'(in_sub);
  assign load = in_valid && ours;
  assign drop = in_valid && !ours;

  pmod_modreg #(.W(W), .IDX_W(IDX_W), .MOD_IDX(MOD_IDX)) u_modreg (
    .clk(clk), .rst_n(rst_n), .sr_idx(sr_idx), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .mod_q(mod_q)
  );

  pmod_arith #(.W(W)) u_arith (
    .op_a(in_a), .op_b(in_b), .modulus(mod_q),
    .is_sub(dir == PM_SUB), .res(calc)
  );

  pmod_outreg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .drop(drop), .data_in(calc),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_result),
    .take_ok(in_ready)
  );

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ours) |=> out_valid);
  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ours && (in_a < mod_q) && (in_b < mod_q))
      |=> (out_result < $past(mod_q)));
endmodule

// File: tb/pmod_addsub_bench.sv
module pmod_addsub_bench;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_sub, out_valid, out_ready, sr_wr;
  logic [2:0]   in_funct;
  logic [W-1:0] in_a, in_b, out_result, sr_wdata, sr_rdata;
  logic [3:0]   sr_idx;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pmod_addsub u_pmod_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_funct(in_funct), .in_sub(in_sub), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .sr_idx(sr_idx), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] v = '0;
    for (int i = 0; i < W / 32; i++) v = {v[W-33:0], $urandom()};
    return v;
  endfunction

  // single-correction formula from R1/R2/R4
  function automatic logic [W-1:0] exp_calc(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub, input logic [W-1:0] m);
    logic [W:0] t;
    if (!sub) begin
      t = {1'b0, a} + {1'b0, b};
      if (t >= {1'b0, m}) t = t - {1'b0, m};
    end else begin
      t = {1'b0, a} - {1'b0, b};
      if (t[W]) t = t + {1'b0, m};
    end
    return t[W-1:0];
  endfunction

  // true modular result for R3
  function automatic logic [W-1:0] true_mod(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub, input logic [W-1:0] m);
    logic [W+1:0] t;
    if (!sub) t = ({2'b0, a} + {2'b0, b}) % {2'b0, m};
    else      t = ({2'b0, a} + {2'b0, m} - {2'b0, b}) % {2'b0, m};
    return t[W-1:0];
  endfunction

  task automatic sr_write(input logic [3:0] idx, input logic [W-1:0] val);
    @(negedge clk);
    sr_idx = idx; sr_wr = 1'b1; sr_wdata = val;
    @(negedge clk);
    sr_wr = 1'b0; sr_idx = 4'd0;
  endtask

  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                       input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_funct = 3'b101; in_sub = sub; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R5 out_valid after accept", W'(out_valid), W'(1));
    check(out_result === exp, tag, out_result, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m, a, b, r;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; sr_wr = 1'b0;
    in_funct = 3'b101; in_sub = 1'b0; in_a = '0; in_b = '0;
    sr_idx = 4'd0; sr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(out_valid === 1'b0, "R10 out_valid after reset", W'(out_valid), '0);
    check(sr_rdata === '0, "R10 modulus after reset", sr_rdata, '0);

    // R8 register access
    m = rand_word() | (W'(1) << (W - 1));
    sr_write(4'd0, m);
    check(sr_rdata === m, "R8 modulus readback", sr_rdata, m);
    sr_write(4'd3, ~m);
    sr_idx = 4'd3;
    #1 check(sr_rdata === '0, "R8 other index reads zero", sr_rdata, '0);
    sr_idx = 4'd0;
    #1 check(sr_rdata === m, "R8 other index write ignored", sr_rdata, m);

    // R1 sum exactly equal to modulus reduces to zero
    a = m >> 1;
    do_op(a, m - a, 1'b0, '0, "R1 sum equals modulus");
    do_op(m - 1, m - 1, 1'b0, m - 2, "R1 both at top of range");
    do_op(W'(5), W'(7), 1'b0, W'(12), "R1 small sum no correction");
    // R2
    do_op(W'(3), W'(10), 1'b1, m - 7, "R2 negative difference");
    do_op(W'(10), W'(3), 1'b1, W'(7), "R2 positive difference");
    do_op(W'(9), W'(9), 1'b1, '0, "R2 zero difference");

    // R4 truncation with out-of-range operands
    sr_write(4'd0, W'(5));
    do_op('1, '1, 1'b0, ~W'(6), "R4 add truncation");
    do_op('0, '1, 1'b1, W'(6), "R4 sub truncation");

    // R3 random in-range
    for (int i = 0; i < 160; i++) begin
      if (i % 20 == 0) begin
        m = rand_word() >> ($urandom() % 200);
        if (m < 2) m = W'(97);
        sr_write(4'd0, m);
      end
      a = rand_word() % m;
      b = rand_word() % m;
      do_op(a, b, i[0], exp_calc(a, b, i[0], m), "R1/R2 random vs formula");
      r = true_mod(a, b, i[0], m);
      check(out_result === r, "R3 random vs true modulo", out_result, r);
      check(out_result < m, "R3 result below modulus", out_result, m);
    end

    // R9 modulus write coinciding with accept
    sr_write(4'd0, W'(100));
    @(negedge clk);
    in_valid = 1'b1; in_funct = 3'b101; in_sub = 1'b0; in_a = W'(60); in_b = W'(50);
    sr_idx = 4'd0; sr_wr = 1'b1; sr_wdata = W'(200);
    @(negedge clk);
    in_valid = 1'b0; sr_wr = 1'b0;
    check(out_result === W'(10), "R9 old modulus used", out_result, W'(10));
    do_op(W'(60), W'(50), 1'b0, W'(110), "R9 new modulus used after");

    // R6 back-pressure
    sr_write(4'd0, W'(100));
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_sub = 1'b0; in_a = W'(30); in_b = W'(40);
    @(negedge clk);
    in_a = W'(90); in_b = W'(20);
    check(out_valid === 1'b1 && out_result === W'(70), "R6 first result present", out_result, W'(70));
    check(in_ready === 1'b0, "R6 in_ready low while stalled", W'(in_ready), '0);
    @(negedge clk);
    check(out_valid === 1'b1 && out_result === W'(70), "R6 result held", out_result, W'(70));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_result === W'(10), "R6 second beat after release", out_result, W'(10));
    @(negedge clk);
    check(out_valid === 1'b0, "R6 drained", W'(out_valid), '0);

    // R7 foreign function code
    @(negedge clk);
    in_valid = 1'b1; in_funct = 3'b100; in_a = W'(1); in_b = W'(2);
    @(negedge clk);
    in_valid = 1'b0; in_funct = 3'b101;
    check(out_valid === 1'b0, "R7 foreign code dropped", W'(out_valid), '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule